// File: doc/BRIEF.md
# Shared RAM Byte Access Window

This block gives a host a narrow, byte-wide window into a RAM that a coprocessor also uses. The host sees four registers: two that load a 16-bit RAM address one byte at a time, a data register that reads or writes the RAM byte at that address, and a control byte. When the control byte enables stepping, every data access moves the address on by one. The host can then upload, download or compare a whole block of RAM by repeated accesses to the data register, without reloading the address.

The control byte also holds the run bit that lets the coprocessor execute or holds it halted. The coprocessor has its own byte port on the same RAM. A liveness handshake works through that shared RAM: the coprocessor leaves 0xFF at an agreed location, and the host reads it and writes 0 back to rearm the check. The RAM array is modelled inside the block. The coprocessor CPU is outside it. The RAM holds 2^RAM_AW bytes, and the low RAM_AW bits of the 16-bit address select the byte.

Top module: `shram_window`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the address is 0x0000, the control byte is 0x00, cpu_run is low and host_rdata is 0x00.
- R2: Host register codes are 0 = address low byte, 1 = address high byte, 2 = data, 3 = control. A write to code 0 or 1 replaces only that byte of the address. A read of code 0 or 1 returns that byte of the current address.
- R3: A host write to code 2 stores host_wdata in RAM entry address[RAM_AW-1:0]. A host read of code 2 returns that entry on host_rdata from the clock edge that ends the read cycle.
- R4: With control bit 0 (step) set, every host data access, read or write, adds one to the 16-bit address, and 0xFFFF wraps to 0x0000.
- R5: With control bit 0 clear, host data accesses leave the address unchanged.
- R6: host_rdata changes only on the edge after a host read. It holds its value through idle cycles and host writes, even when the RAM byte it came from is overwritten.
- R7: Control bit 1 is the run bit and drives cpu_run. Bits 1:0 read back as written, and bits 7:2 read as 0.
- R8: A coprocessor write stores cp_wdata at cp_addr. cp_rdata shows the entry at cp_addr one cycle later. Bytes written on either port are visible on the other.
- R9: If the host and the coprocessor write the same RAM entry in the same cycle, the host byte is kept. Writes to different entries in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read for this access |
| host_reg | input | 2 | Register code (see R2) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| cpu_run | output | 1 | Coprocessor run enable |
| cp_we | input | 1 | Coprocessor write strobe |
| cp_addr | input | RAM_AW | Coprocessor RAM index |
| cp_wdata | input | 8 | Coprocessor write byte |
| cp_rdata | output | 8 | Coprocessor read byte, one-cycle latency |

## Verification
The assertions assume that host_req is a single-cycle strobe carrying exactly one register access, and that no access is in flight during reset. The bench drives each access for exactly one cycle, between falling edges, and keeps inputs idle while reset is low. The collision property reads the array entry one cycle after a shared write. For that reason the bench only starts a collision with both ports held otherwise idle, then sweeps every entry in both directions with a small RAM.

// File: rtl/shram_pkg.sv
// Package: shared register codes and control-bit positions for the
// shared RAM window. Assumes a byte-wide host bus with a 2-bit register code.
package shram_pkg;
    localparam int WIN_ADDR_W = 16;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        REG_ADDR_LO = 2'd0,
        REG_ADDR_HI = 2'd1,
        REG_DATA    = 2'd2,
        REG_CTRL    = 2'd3
    } win_reg_e;

    localparam int CTRL_STEP_BIT = 0;
    localparam int CTRL_RUN_BIT  = 1;
endpackage

// File: rtl/shram_addr_ptr.sv
// Module: 16-bit address pointer loaded one byte at a time, with optional
// post-access increment. Assumes at most one of load_lo/load_hi/step per cycle.
module shram_addr_ptr
    import shram_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_lo,
    input  logic                  load_hi,
    input  logic                  step,
    input  logic [BYTE_W-1:0]     wbyte,
    output logic [WIN_ADDR_W-1:0] addr
);
    localparam int HALF_W = WIN_ADDR_W / 2;

    logic [WIN_ADDR_W-1:0] addr_q;
    logic [WIN_ADDR_W-1:0] addr_d;

    // Next-address selection: byte loads replace one half, step adds one.
    always_comb begin
        addr_d = addr_q;
        if (load_lo)
            addr_d[HALF_W-1:0] = wbyte;
        else if (load_hi)
            addr_d[WIN_ADDR_W-1:HALF_W] = wbyte;
        else if (step)
            addr_d = addr_q + WIN_ADDR_W'(1);
    end

    // Address register with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

    assign addr = addr_q;

    assert_step_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_lo && !load_hi) |=> addr == $past(addr) + WIN_ADDR_W'(1));

    assert_addr_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_lo && !load_hi) |=> $stable(addr));

    assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> (addr[HALF_W-1:0] == $past(wbyte)) &&
                    (addr[WIN_ADDR_W-1:HALF_W] == $past(addr[WIN_ADDR_W-1:HALF_W])));
endmodule

// File: rtl/shram_ctrl.sv
// Module: control byte holding the step-enable and run bits.
// Assumes ctrl_wr is a one-cycle strobe. Unused bits read back as zero.
module shram_ctrl
    import shram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              step_en,
    output logic              run,
    output logic [BYTE_W-1:0] ctrl_byte
);
    logic step_q;
    logic run_q;

    // Capture the two live control bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 1'b0;
            run_q  <= 1'b0;
        end else if (ctrl_wr) begin
            step_q <= wbyte[CTRL_STEP_BIT];
            run_q  <= wbyte[CTRL_RUN_BIT];
        end
    end

    // Assemble the readback byte with unused bits zero.
    always_comb begin
        ctrl_byte = '0;
        ctrl_byte[CTRL_STEP_BIT] = step_q;
        ctrl_byte[CTRL_RUN_BIT]  = run_q;
    end

    assign step_en = step_q;
    assign run     = run_q;

    assert_run_tracks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> run == $past(wbyte[CTRL_RUN_BIT]));

    assert_run_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(run) && $stable(step_en));
endmodule

// File: rtl/shram_dpram.sv
// Module: two-port byte RAM. The host port has a read register, and the
// coprocessor port reads every cycle. Same-entry writes: the host wins.
// Assumes the host reads and writes in different cycles.
module shram_dpram
    import shram_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic              h_re,
    input  logic [RAM_AW-1:0] h_idx,
    input  logic [BYTE_W-1:0] h_wdata,
    output logic [BYTE_W-1:0] h_rdata,
    input  logic              cp_we,
    input  logic [RAM_AW-1:0] cp_idx,
    input  logic [BYTE_W-1:0] cp_wdata,
    output logic [BYTE_W-1:0] cp_rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] h_rd_q;
    logic [BYTE_W-1:0] cp_rd_q;
    logic              cp_blocked;

    // Coprocessor write is dropped when the host writes the same entry.
    assign cp_blocked = h_we && (h_idx == cp_idx);

    // Array update for both write ports.
    always_ff @(posedge clk) begin
        if (cp_we && !cp_blocked)
            mem[cp_idx] <= cp_wdata;
        if (h_we)
            mem[h_idx] <= h_wdata;
    end

    // Host read register, loaded only on a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            h_rd_q <= '0;
        else if (h_re)
            h_rd_q <= mem[h_idx];
    end

    // Coprocessor read register, loaded every cycle.
    always_ff @(posedge clk) begin
        cp_rd_q <= mem[cp_idx];
    end

    assign h_rdata  = h_rd_q;
    assign cp_rdata = cp_rd_q;

    assert_host_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && cp_we && h_idx == cp_idx) |=> mem[$past(h_idx)] == $past(h_wdata));

    assert_cp_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_we && !(h_we && h_idx == cp_idx)) |=> mem[$past(cp_idx)] == $past(cp_wdata));

    assert_host_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        h_we |=> mem[$past(h_idx)] == $past(h_wdata));
endmodule

// File: rtl/shram_window.sv
// Module: host register window onto a shared byte RAM, with a byte-loaded
// 16-bit address, an auto-stepping data port, a control byte with run/step
// bits, and a separate coprocessor RAM port.
// Assumes host_req is a one-cycle strobe per access and RAM_AW <= 16.
module shram_window
    import shram_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [1:0]        host_reg,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              cpu_run,
    input  logic              cp_we,
    input  logic [RAM_AW-1:0] cp_addr,
    input  logic [7:0]        cp_wdata,
    output logic [7:0]        cp_rdata
);
    localparam int HALF_W = WIN_ADDR_W / 2;

    win_reg_e              reg_sel;
    logic                  data_acc;
    logic                  load_lo;
    logic                  load_hi;
    logic                  ctrl_wr;
    logic                  step_en;
    logic [WIN_ADDR_W-1:0] addr;
    logic [BYTE_W-1:0]     ctrl_byte;
    logic [BYTE_W-1:0]     ram_rdata;
    logic [BYTE_W-1:0]     reg_view;
    logic [BYTE_W-1:0]     hold_q;
    logic                  from_ram_q;

    // Decode the host strobe into per-register actions.
    always_comb begin
        reg_sel  = win_reg_e'(host_reg);
        data_acc = host_req && (reg_sel == REG_DATA);
        load_lo  = host_req && host_we && (reg_sel == REG_ADDR_LO);
        load_hi  = host_req && host_we && (reg_sel == REG_ADDR_HI);
        ctrl_wr  = host_req && host_we && (reg_sel == REG_CTRL);
    end

    shram_addr_ptr u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .step    (data_acc && step_en),
        .wbyte   (host_wdata),
        .addr    (addr)
    );

    shram_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wbyte     (host_wdata),
        .step_en   (step_en),
        .run       (cpu_run),
        .ctrl_byte (ctrl_byte)
    );

    shram_dpram #(.RAM_AW(RAM_AW)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_we     (data_acc && host_we),
        .h_re     (data_acc && !host_we),
        .h_idx    (addr[RAM_AW-1:0]),
        .h_wdata  (host_wdata),
        .h_rdata  (ram_rdata),
        .cp_we    (cp_we),
        .cp_idx   (cp_addr),
        .cp_wdata (cp_wdata),
        .cp_rdata (cp_rdata)
    );

    // Value of a non-data register, as seen by a host read.
    always_comb begin
        case (reg_sel)
            REG_ADDR_LO: reg_view = addr[HALF_W-1:0];
            REG_ADDR_HI: reg_view = addr[WIN_ADDR_W-1:HALF_W];
            REG_CTRL:    reg_view = ctrl_byte;
            default:     reg_view = '0;
        endcase
    end

    // Capture register reads and remember which source the last read used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            from_ram_q <= 1'b0;
        end else if (host_req && !host_we) begin
            from_ram_q <= (reg_sel == REG_DATA);
            if (reg_sel != REG_DATA)
                hold_q <= reg_view;
        end
    end

    assign host_rdata = from_ram_q ? ram_rdata : hold_q;

    assert_rdata_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && !host_we) |=> $stable(host_rdata));

    assert_single_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({data_acc, load_lo, load_hi, ctrl_wr}) <= 1);
endmodule

// File: tb/test_shram_window.sv
module test_shram_window;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] ALIVE_IDX = 8'h7E;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [1:0]    host_reg = 2'd0;
    logic [7:0]    host_wdata = 8'h00;
    logic [7:0]    host_rdata;
    logic          cpu_run;
    logic          cp_we = 1'b0;
    logic [AW-1:0] cp_addr = '0;
    logic [7:0]    cp_wdata = 8'h00;
    logic [7:0]    cp_rdata;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    shram_window #(.RAM_AW(AW)) i_shram_window (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cpu_run(cpu_run), .cp_we(cp_we), .cp_addr(cp_addr),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata)
    );

    function automatic logic [7:0] pat_a(int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    function automatic logic [7:0] pat_b(int i);
        return 8'((i * 91) ^ 8'hC3);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [1:0] r, logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_reg = r; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(logic [1:0] r, output logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_reg = r;
        @(negedge clk);
        host_req = 1'b0;
        d = host_rdata;
    endtask

    task automatic set_addr(logic [15:0] a);
        hwrite(2'd0, a[7:0]);
        hwrite(2'd1, a[15:8]);
    endtask

    task automatic cwrite(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        cp_we = 1'b1; cp_addr = a; cp_wdata = d;
        @(negedge clk);
        cp_we = 1'b0;
    endtask

    task automatic cread(logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        cp_addr = a;
        @(negedge clk);
        d = cp_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 rdata", host_rdata, 8'h00);
        check("R1 run", {7'd0, cpu_run}, 8'h00);
        hread(2'd0, v); check("R1 addr lo", v, 8'h00);
        hread(2'd1, v); check("R1 addr hi", v, 8'h00);
        hread(2'd3, v); check("R1 ctrl", v, 8'h00);

        // R2: address byte loads are independent
        set_addr(16'hA53C);
        hread(2'd0, v); check("R2 lo", v, 8'h3C);
        hread(2'd1, v); check("R2 hi", v, 8'hA5);
        hwrite(2'd0, 8'h11);
        hread(2'd1, v); check("R2 hi kept", v, 8'hA5);
        hread(2'd0, v); check("R2 lo new", v, 8'h11);

        // R3/R4: stepped upload of every entry, then stepped download
        hwrite(2'd3, 8'h01);
        set_addr(16'h0000);
        for (int i = 0; i < DEPTH; i++) hwrite(2'd2, pat_a(i));
        hread(2'd0, v); check("R4 lo after upload", v, 8'h00);
        hread(2'd1, v); check("R4 hi after upload", v, 8'h01);
        set_addr(16'h0000);
        for (int i = 0; i < DEPTH; i++) begin
            hread(2'd2, v);
            check($sformatf("R3 entry %0d", i), v, pat_a(i));
        end
        hread(2'd1, v); check("R4 hi after download", v, 8'h01);

        // R4: wrap from 0xFFFF, entry index is low bits
        set_addr(16'hFFFF);
        hwrite(2'd2, 8'h5A);
        hread(2'd0, v); check("R4 wrap lo", v, 8'h00);
        hread(2'd1, v); check("R4 wrap hi", v, 8'h00);
        cread(8'hFF, v); check("R3 index low bits", v, 8'h5A);

        // R5: no stepping when bit 0 is clear
        hwrite(2'd3, 8'h00);
        set_addr(16'h0010);
        hwrite(2'd2, 8'h11);
        hwrite(2'd2, 8'h22);
        hread(2'd0, v); check("R5 addr fixed", v, 8'h10);
        hread(2'd2, v); check("R5 last write", v, 8'h22);
        hread(2'd2, v); check("R5 same entry", v, 8'h22);
        hread(2'd0, v); check("R5 addr still", v, 8'h10);
        cread(8'h11, v); check("R5 neighbour untouched", v, pat_a(8'h11));

        // R6: read data held through idle and overwrite
        hread(2'd2, keep);
        cwrite(8'h10, 8'hE7);
        repeat (3) @(negedge clk);
        check("R6 hold idle", host_rdata, keep);
        hwrite(2'd0, 8'h10);
        check("R6 hold over write", host_rdata, keep);

        // R7: run bit and control readback
        hwrite(2'd3, 8'hFE);
        check("R7 run set", {7'd0, cpu_run}, 8'h01);
        hread(2'd3, v); check("R7 ctrl rb", v, 8'h02);
        hwrite(2'd3, 8'h03);
        hread(2'd3, v); check("R7 ctrl rb3", v, 8'h03);
        hwrite(2'd3, 8'h01);
        check("R7 run clear", {7'd0, cpu_run}, 8'h00);

        // R8: coprocessor sweep, host download
        for (int i = 0; i < DEPTH; i++) cwrite(AW'(i), pat_b(i));
        set_addr(16'h0300);
        for (int i = 0; i < DEPTH; i++) begin
            hread(2'd2, v);
            check($sformatf("R8 cp entry %0d", i), v, pat_b(i));
        end

        // R8: liveness handshake through the shared RAM
        hwrite(2'd3, 8'h02);
        cwrite(ALIVE_IDX, 8'hFF);
        set_addr({8'h00, ALIVE_IDX});
        hread(2'd2, v); check("R8 alive seen", v, 8'hFF);
        hwrite(2'd2, 8'h00);
        cread(ALIVE_IDX, v); check("R8 alive rearmed", v, 8'h00);

        // R9: same-entry collision, host wins
        set_addr(16'h0040);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_reg = 2'd2; host_wdata = 8'hAA;
        cp_we = 1'b1; cp_addr = 8'h40; cp_wdata = 8'h55;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; cp_we = 1'b0;
        cread(8'h40, v); check("R9 host wins", v, 8'hAA);

        // R9: different entries in one cycle both land
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_reg = 2'd2; host_wdata = 8'h3C;
        cp_we = 1'b1; cp_addr = 8'h41; cp_wdata = 8'hC3;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; cp_we = 1'b0;
        cread(8'h41, v); check("R9 cp lands", v, 8'hC3);
        hread(2'd2, v); check("R9 host lands", v, 8'h3C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule